// File: doc/BRIEF.md
# NAPOT Memory Protection Checker

This block guards memory accesses against a small set of protection regions. Each region has an 8-bit configuration byte and an address register, both written and read through a simple register port. The configuration byte holds read, write and execute permissions, an address-matching mode and a lock flag. A region is either switched off, matches one naturally aligned 4-byte word, or matches a naturally aligned power-of-two block whose size comes from the trailing ones of its address register.

For every access the block takes a word address, an access kind and a user/machine flag. It finds the lowest-numbered region that matches and decides whether the access is allowed. One cycle later it reports a result strobe with a fault flag. A granularity parameter sets the smallest region the block can describe. Any region can be fixed at elaboration time, so that software cannot change it.

A typical arrangement places fixed regions at the highest indices as defaults for user code. Lower-numbered programmable regions then override them where needed.

Top module: `napot_guard`

## Requirements
- R1: After reset every programmable region reads a configuration byte of 0x00 and an address of 0. `res_valid` and `res_fault` are low.
- R2: The configuration byte has this layout: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 mode (0 off, 1 unsupported, 2 single word, 3 power-of-two block), bits 6:5 reserved and read as 0, bit 7 lock. A write with `csr_sel`=0 stores the byte. A write with `csr_sel`=1 stores the address register. Both read back combinationally on `csr_rdata` for the selected `csr_idx`.
- R3: Mode 1 is never stored; writing it stores mode 0 instead. When `GRAIN` > 0, writing mode 2 also stores mode 0. The other bits of the byte are kept.
- R4: When `GRAIN` > 1, the low `GRAIN`-1 bits of a programmable region's address read as 0 while its mode is 0 and as 1 while its mode is 3. Matching uses the same adjusted value. The written bits are kept underneath and show again when the mode changes.
- R5: While a programmable region's lock bit is set, writes to its configuration byte and its address register are ignored.
- R6: A region whose `HW_MASK` bit is set always reads the `HW_CFG` and `HW_ADDR` values, ignores all writes, and is not subject to the rules of R3 and R4.
- R7: In mode 3, an address register with k trailing ones covers the 2^(k+3)-byte block it aligns to. In mode 2 the region covers exactly one word.
- R8: When several regions match an access, the lowest-numbered one alone decides the outcome.
- R9: A user access (`chk_user`=1) that matches no region faults. A user access that matches a region faults unless that region's permission bit for the access kind is set.
- R10: A machine access that matches no region is allowed. A machine access that matches an unlocked region is allowed. A machine access that matches a locked region is checked like a user access.
- R11: `res_valid` is high exactly in the cycle after `chk_valid` was sampled high. `res_fault` is low whenever `res_valid` is low.
- R12: `chk_kind` 0 is a read (checked against bit 0), 1 a write (bit 1), 2 an execute (bit 2). Kind 3 is denied wherever permissions are enforced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 1 | 0 selects the configuration byte, 1 selects the address register |
| csr_idx | input | IDX_W | Region index for read and write |
| csr_wdata | input | PA_W | Write data (bits 7:0 for a configuration byte) |
| csr_rdata | output | PA_W | Read data of the selected register |
| chk_valid | input | 1 | Access check request |
| chk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| chk_user | input | 1 | 1 for a user-mode access, 0 for machine mode |
| chk_waddr | input | PA_W | Word address of the access (byte address bits above 1:0) |
| res_valid | output | 1 | Check result strobe, one cycle after the request |
| res_fault | output | 1 | The checked access is denied |

## Verification
The bench probes the edges of each block: the last word inside a region and the first word past it. A wrong trailing-ones size decode moves that fault boundary. It overlaps a programmable region on a fixed one. A resolver that let the higher index win would then deny a write that should pass. The bench reads back the adjusted address bits while toggling the mode, and it writes single-word and unsupported modes with a nonzero granularity. A design that stored the raw bits would show them on readback. It locks a region and then tries to rewrite it and to access it from machine mode. A design that ignored the lock would either take the rewrite or let the machine write through.

// File: rtl/napot_guard_pkg.sv
package napot_guard_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_TOR   = 2'd1,
        MODE_NA4   = 2'd2,
        MODE_NAPOT = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic       lock;
        logic [1:0] rsvd;
        amode_e     mode;
        logic       x;
        logic       w;
        logic       r;
    } region_cfg_t;

endpackage

// File: rtl/napot_guard_regs.sv
module napot_guard_regs
    import napot_guard_pkg::*;
#(
    parameter int N_REGIONS = 4,
    parameter int PA_W      = 30,
    parameter int GRAIN     = 2,
    parameter int IDX_W     = 2,
    parameter logic [N_REGIONS-1:0]      HW_MASK = '0,
    parameter logic [N_REGIONS*PA_W-1:0] HW_ADDR = '0,
    parameter logic [N_REGIONS*8-1:0]    HW_CFG  = '0
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic                            wr_sel,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [PA_W-1:0]                 wr_data,
    output region_cfg_t [N_REGIONS-1:0]     cfg_o,
    output logic [N_REGIONS-1:0][PA_W-1:0]  addr_eff_o
);

    typedef struct packed {
        region_cfg_t [N_REGIONS-1:0]    cfg;
        logic [N_REGIONS-1:0][PA_W-1:0] addr;
    } bank_t;

    function automatic logic [PA_W-1:0] grain_mask();
        logic [PA_W-1:0] m;
        for (int b = 0; b < PA_W; b++) begin
            m[b] = (b < GRAIN - 1);
        end
        return m;
    endfunction

    localparam logic [PA_W-1:0] LOW_MASK = grain_mask();

    function automatic bank_t init_bank();
        bank_t b;
        b = '0;
        for (int i = 0; i < N_REGIONS; i++) begin
            if (HW_MASK[i]) begin
                b.cfg[i]  = region_cfg_t'(HW_CFG[i*8 +: 8]);
                b.addr[i] = HW_ADDR[i*PA_W +: PA_W];
            end
        end
        return b;
    endfunction

    localparam bank_t RST_BANK = init_bank();

    function automatic region_cfg_t clean_cfg(input logic [7:0] raw);
        region_cfg_t c;
        c      = region_cfg_t'(raw);
        c.rsvd = '0;
        if (c.mode == MODE_TOR) begin
            c.mode = MODE_OFF;
        end
        if (c.mode == MODE_NA4 && GRAIN > 0) begin
            c.mode = MODE_OFF;
        end
        return c;
    endfunction

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < N_REGIONS; i++) begin
            if (HW_MASK[i]) begin
                bank_d.cfg[i]  = RST_BANK.cfg[i];
                bank_d.addr[i] = RST_BANK.addr[i];
            end else if (wr_en && wr_idx == IDX_W'(i) && !bank_q.cfg[i].lock) begin
                if (wr_sel) begin
                    bank_d.addr[i] = wr_data;
                end else begin
                    bank_d.cfg[i] = clean_cfg(wr_data[7:0]);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= RST_BANK;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign cfg_o = bank_q.cfg;

    for (genvar g = 0; g < N_REGIONS; g++) begin : g_eff
        if (HW_MASK[g] || GRAIN < 2) begin : g_raw
            assign addr_eff_o[g] = bank_q.addr[g];
        end else begin : g_adj
            always_comb begin
                case (bank_q.cfg[g].mode)
                    MODE_OFF:   addr_eff_o[g] = bank_q.addr[g] & ~LOW_MASK;
                    MODE_NAPOT: addr_eff_o[g] = bank_q.addr[g] | LOW_MASK;
                    default:    addr_eff_o[g] = bank_q.addr[g];
                endcase
            end
        end
    end

endmodule

// File: rtl/napot_guard_match.sv
module napot_guard_match
    import napot_guard_pkg::*;
#(
    parameter int PA_W = 30
) (
    input  region_cfg_t     cfg,
    input  logic [PA_W-1:0] addr_eff,
    input  logic [PA_W-1:0] acc_pa,
    output logic            hit
);

    logic [PA_W-1:0] span;
    logic [PA_W-1:0] care;

    always_comb begin
        span = addr_eff ^ (addr_eff + PA_W'(1));
        care = ~span;
        case (cfg.mode)
            MODE_NAPOT: hit = ((acc_pa ^ addr_eff) & care) == '0;
            MODE_NA4:   hit = (acc_pa == addr_eff);
            default:    hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/napot_guard.sv
module napot_guard
    import napot_guard_pkg::*;
#(
    parameter int N_REGIONS = 4,
    parameter int ADDR_W    = 32,
    parameter int GRAIN     = 2,
    parameter int PA_W      = ADDR_W - 2,
    parameter int IDX_W     = (N_REGIONS > 1) ? $clog2(N_REGIONS) : 1,
    parameter logic [N_REGIONS-1:0]      HW_MASK = 4'b1000,
    parameter logic [N_REGIONS*PA_W-1:0] HW_ADDR = {30'h0800_1FFF, {3{30'h0}}},
    parameter logic [N_REGIONS*8-1:0]    HW_CFG  = {8'h19, 24'h0}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_we,
    input  logic             csr_sel,
    input  logic [IDX_W-1:0] csr_idx,
    input  logic [PA_W-1:0]  csr_wdata,
    output logic [PA_W-1:0]  csr_rdata,
    input  logic             chk_valid,
    input  logic [1:0]       chk_kind,
    input  logic             chk_user,
    input  logic [PA_W-1:0]  chk_waddr,
    output logic             res_valid,
    output logic             res_fault
);

    typedef struct packed {
        logic valid;
        logic fault;
    } res_t;

    region_cfg_t [N_REGIONS-1:0]    cfg_vec;
    logic [N_REGIONS-1:0][PA_W-1:0] addr_eff;
    logic [N_REGIONS-1:0]           hit_vec;
    logic [N_REGIONS*8-1:0]         cfg_flat;
    logic [N_REGIONS*PA_W-1:0]      addr_flat;
    logic                           any_hit;
    region_cfg_t                    win_cfg;
    logic                           perm_ok;
    logic                           enforce;
    logic                           allow;
    res_t                           res_d, res_q;

    napot_guard_regs #(
        .N_REGIONS (N_REGIONS),
        .PA_W      (PA_W),
        .GRAIN     (GRAIN),
        .IDX_W     (IDX_W),
        .HW_MASK   (HW_MASK),
        .HW_ADDR   (HW_ADDR),
        .HW_CFG    (HW_CFG)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (csr_we),
        .wr_sel     (csr_sel),
        .wr_idx     (csr_idx),
        .wr_data    (csr_wdata),
        .cfg_o      (cfg_vec),
        .addr_eff_o (addr_eff)
    );

    for (genvar g = 0; g < N_REGIONS; g++) begin : g_match
        napot_guard_match #(
            .PA_W (PA_W)
        ) u_match (
            .cfg      (cfg_vec[g]),
            .addr_eff (addr_eff[g]),
            .acc_pa   (chk_waddr),
            .hit      (hit_vec[g])
        );
    end

    assign cfg_flat  = cfg_vec;
    assign addr_flat = addr_eff;

    // Register read port
    always_comb begin
        csr_rdata = '0;
        for (int i = 0; i < N_REGIONS; i++) begin
            if (csr_idx == IDX_W'(i)) begin
                csr_rdata = csr_sel ? addr_eff[i] : PA_W'(cfg_vec[i]);
            end
        end
    end

    // Lowest index wins: scan downward so the last hit assigned is the lowest
    always_comb begin
        any_hit = 1'b0;
        win_cfg = '0;
        for (int i = N_REGIONS - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit = 1'b1;
                win_cfg = cfg_vec[i];
            end
        end
        case (acc_e'(chk_kind))
            ACC_READ:  perm_ok = win_cfg.r;
            ACC_WRITE: perm_ok = win_cfg.w;
            ACC_EXEC:  perm_ok = win_cfg.x;
            default:   perm_ok = 1'b0;
        endcase
        enforce = chk_user || win_cfg.lock;
        if (any_hit) begin
            allow = enforce ? perm_ok : 1'b1;
        end else begin
            allow = !chk_user;
        end
        res_d.valid = chk_valid;
        res_d.fault = chk_valid && !allow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid = res_q.valid;
    assign res_fault = res_q.fault;

endmodule

// File: rtl/napot_guard_chk.sv
module napot_guard_chk #(
    parameter int N_REGIONS = 4,
    parameter int PA_W      = 30
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      chk_valid,
    input logic                      chk_user,
    input logic                      res_valid,
    input logic                      res_fault,
    input logic                      any_hit,
    input logic [N_REGIONS*8-1:0]    cfg_flat,
    input logic [N_REGIONS*PA_W-1:0] addr_flat
);

    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> res_valid); // R11
    AST_NO_EXTRA_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !res_valid); // R11
    AST_FAULT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !res_fault); // R11
    AST_USER_MISS_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_user && !any_hit) |=> res_fault); // R9
    AST_MACHINE_MISS_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !chk_user && !any_hit) |=> !res_fault); // R10

    for (genvar g = 0; g < N_REGIONS; g++) begin : g_reg
        AST_LOCKED_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_flat[g*8+7] |=> $stable(cfg_flat[g*8 +: 8])); // R5
        AST_LOCKED_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_flat[g*8+7] |=> $stable(addr_flat[g*PA_W +: PA_W])); // R5
        AST_NO_TOR_STORED: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_flat[g*8+3 +: 2] != 2'b01); // R3
    end

endmodule

bind napot_guard napot_guard_chk #(
    .N_REGIONS (N_REGIONS),
    .PA_W      (PA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_valid (chk_valid),
    .chk_user  (chk_user),
    .res_valid (res_valid),
    .res_fault (res_fault),
    .any_hit   (any_hit),
    .cfg_flat  (cfg_flat),
    .addr_flat (addr_flat)
);

// File: tb/napot_guard_tb.sv
module napot_guard_tb;

    localparam int PA_W = 30;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            csr_we = 1'b0;
    logic            csr_sel = 1'b0;
    logic [1:0]      csr_idx = '0;
    logic [PA_W-1:0] csr_wdata = '0;
    logic [PA_W-1:0] csr_rdata;
    logic            chk_valid = 1'b0;
    logic [1:0]      chk_kind = '0;
    logic            chk_user = 1'b0;
    logic [PA_W-1:0] chk_waddr = '0;
    logic            res_valid;
    logic            res_fault;

    int n_tests = 0;
    int n_fail  = 0;
    bit   exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    napot_guard u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_we    (csr_we),
        .csr_sel   (csr_sel),
        .csr_idx   (csr_idx),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .chk_valid (chk_valid),
        .chk_kind  (chk_kind),
        .chk_user  (chk_user),
        .chk_waddr (chk_waddr),
        .res_valid (res_valid),
        .res_fault (res_fault)
    );

    task automatic note(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic csr_write(input bit sel, input int idx, input logic [PA_W-1:0] data);
        @(negedge clk);
        csr_we = 1'b1; csr_sel = sel; csr_idx = 2'(idx); csr_wdata = data;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic csr_check(input bit sel, input int idx, input logic [PA_W-1:0] exp, input string tag);
        @(negedge clk);
        csr_sel = sel; csr_idx = 2'(idx);
        #1;
        note(csr_rdata == exp, tag, 32'(csr_rdata), 32'(exp));
    endtask

    // Driver: push expected fault, present request for one cycle
    task automatic access(input logic [31:0] baddr, input int kind, input bit user, input bit exp_fault, input string tag);
        @(negedge clk);
        chk_valid = 1'b1; chk_kind = 2'(kind); chk_user = user; chk_waddr = baddr[31:2];
        exp_q.push_back(exp_fault);
        tag_q.push_back(tag);
        @(negedge clk);
        chk_valid = 1'b0;
    endtask

    // Monitor: every result strobe pops one expectation
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (exp_q.size() == 0) begin
                note(1'b0, "R11 unexpected result", 32'(res_fault), 32'h0);
            end else begin
                bit    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                note(res_fault == e, t, 32'(res_fault), 32'(e));
            end
        end
    end

    initial begin
        #3_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        note(res_valid == 1'b0, "R1 res_valid in reset", 32'(res_valid), 32'h0);
        csr_check(1'b0, 0, '0, "R1 cfg0 reset");
        csr_check(1'b1, 0, '0, "R1 addr0 reset");
        csr_check(1'b1, 3, 30'h0800_1FFF, "R6 hardwired addr3");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        note(res_valid == 1'b0 && res_fault == 1'b0, "R1 outputs after reset", 32'({res_valid, res_fault}), 32'h0);

        // Region 0: 0x1000..0x1FFF read/write, NAPOT
        csr_write(1'b0, 0, 30'h1B);
        csr_check(1'b0, 0, 30'h1B, "R2 cfg0 readback");
        csr_write(1'b1, 0, 30'h5FF);
        csr_check(1'b1, 0, 30'h5FF, "R2 addr0 readback");
        csr_write(1'b0, 0, 30'h7B);
        csr_check(1'b0, 0, 30'h1B, "R2 reserved bits read zero");

        // Region 1 grain rule
        csr_write(1'b1, 1, 30'h101);
        csr_check(1'b1, 1, 30'h100, "R4 low bit zero while off");
        csr_write(1'b0, 1, 30'h1C);
        csr_check(1'b1, 1, 30'h101, "R4 low bit one while napot");

        // Region 2 mode coercion
        csr_write(1'b0, 2, 30'h11);
        csr_check(1'b0, 2, 30'h01, "R3 single-word mode stored off");
        csr_write(1'b0, 2, 30'h0A);
        csr_check(1'b0, 2, 30'h02, "R3 unsupported mode stored off");

        // Region 3 hardwired
        csr_write(1'b0, 3, 30'h0);
        csr_write(1'b1, 3, 30'h0);
        csr_check(1'b0, 3, 30'h19, "R6 hardwired cfg ignores write");
        csr_check(1'b1, 3, 30'h0800_1FFF, "R6 hardwired addr ignores write");

        // User accesses
        access(32'h0000_1004, 0, 1'b1, 1'b0, "R9 user read inside rw region");
        access(32'h0000_1004, 2, 1'b1, 1'b1, "R12 user exec without X");
        access(32'h0000_1FFC, 1, 1'b1, 1'b0, "R7 user write last word of region");
        access(32'h0000_2000, 0, 1'b1, 1'b1, "R7 first word past region");
        access(32'h0000_0FFC, 0, 1'b1, 1'b1, "R7 word below region");
        access(32'h0000_0408, 2, 1'b1, 1'b0, "R12 exec in X region");
        access(32'h0000_040C, 0, 1'b1, 1'b1, "R12 read in X-only region");
        access(32'h0000_0410, 2, 1'b1, 1'b1, "R7 16-byte region end");
        access(32'h0000_1004, 3, 1'b1, 1'b1, "R12 kind 3 denied");
        access(32'h2000_FFFC, 0, 1'b1, 1'b0, "R6 user read in hardwired region");
        access(32'h2000_FFFC, 1, 1'b1, 1'b1, "R9 user write read-only region");
        access(32'h2001_0000, 0, 1'b1, 1'b1, "R9 user miss faults");

        // Machine accesses
        access(32'h0000_2000, 1, 1'b0, 1'b0, "R10 machine miss allowed");
        access(32'h0000_1004, 2, 1'b0, 1'b0, "R10 machine unlocked region allowed");
        access(32'h2000_0000, 1, 1'b0, 1'b0, "R10 machine hardwired unlocked");

        // Priority: region 2 RW over 0x2000_0000..0x2000_0FFF
        csr_write(1'b1, 2, 30'h0800_01FF);
        csr_write(1'b0, 2, 30'h1B);
        access(32'h2000_0010, 1, 1'b1, 1'b0, "R8 lower region overrides");
        access(32'h2000_2000, 1, 1'b1, 1'b1, "R8 higher region outside overlap");

        // Lock region 0 read-only
        csr_write(1'b0, 0, 30'h99);
        csr_check(1'b0, 0, 30'h99, "R2 lock bit readback");
        access(32'h0000_1004, 1, 1'b0, 1'b1, "R10 machine write to locked RO");
        access(32'h0000_1004, 0, 1'b0, 1'b0, "R10 machine read locked R");
        csr_write(1'b0, 0, 30'h1F);
        csr_write(1'b1, 0, 30'h0);
        csr_check(1'b0, 0, 30'h99, "R5 locked cfg ignores write");
        csr_check(1'b1, 0, 30'h5FF, "R5 locked addr ignores write");
        access(32'h0000_1FFC, 0, 1'b1, 1'b0, "R5 locked region still matches");

        repeat (3) @(negedge clk);
        note(exp_q.size() == 0, "R11 results outstanding", 32'(exp_q.size()), 32'h0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule